// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block is an 8-bit bidirectional port for a host bus, with two strobe lines. The input strobe `stb_in` is sampled against its previous level to find edges, and one control bit picks which edge counts. The output strobe `stb_out` is active high and signals readiness or data availability. The host selects one of three modes through the control register. Simple strobed mode latches the port on every active strobe edge and pulses the output strobe whenever the auxiliary output register is written. Input handshake mode asks the far side for data and waits for the host to take it. Output handshake mode presents data and waits for an acknowledge. Output handshake runs as a three-state variant whenever any direction bit is clear.

A status flag records each active strobe edge. The only way to clear it is a two-step read: read the control register while the flag is set, then read the latched data register. The strobe input is taken as already synchronous to `clk`. Pin drive is given as separate data (`pin_out`) and enable (`pin_oe`) vectors. All register reads are combinational decodes of `bus_addr`, and any side effects of a read take place at the clock edge where `bus_rd` is high.

The handshake state machine has six states. S_SIMPLE covers simple mode. S_IN_READY means the port is ready to latch, and S_IN_FULL means data is latched and waits for the host. S_OUT_EMPTY means no data is pending, S_OUT_READY means data is presented, and S_OUT_ACK means an acknowledge is in progress in the three-state variant. The transitions are:
- Any control write goes to the entry state of the newly selected mode: S_SIMPLE, S_IN_READY or S_OUT_EMPTY.
- S_IN_READY goes to S_IN_FULL on an active edge.
- S_IN_FULL goes to S_IN_READY on a latched-register read.
- S_OUT_EMPTY goes to S_OUT_READY on a latched-register write.
- S_OUT_READY goes to S_OUT_EMPTY on an active edge when all direction bits are set. It goes to S_OUT_ACK on an active edge otherwise.
- S_OUT_ACK goes to S_OUT_EMPTY on the trailing edge.

Top module: `pio_hs_port`

## Requirements
- R1: After reset the mode is simple, the control register reads 0x00, the direction register reads 0x00, `pin_oe` is 0x00 and `stb_out` is low.
- R2: The control register at address 0 is laid out as follows. Bit 1 selects the rising edge as active (0 selects falling). Bit 2 selects pulse style for the strobe output. Bit 3 selects output handshake. Bit 4 enables handshake. Bit 7 is the flag. Bits 0, 5 and 6 read 0, and a write to bit 7 is ignored.
- R3: Only the selected edge of `stb_in` is active. A change of `stb_in` seen at one clock edge takes effect in the registers updated at that same edge.
- R4: In simple mode and input handshake mode, every active edge copies `pin_in` into the latched data register at address 1.
- R5: The flag is set by every active edge. It clears only when a latched-register read follows a control-register read taken while the flag was 1. A latched-register read alone leaves the flag set.
- R6: In input handshake mode with level style, `stb_out` is high in S_IN_READY. It goes low after the capturing edge and goes high again after the latched-register read.
- R7: In output handshake mode with all direction bits set, a latched-register write drives that data on `pin_out` and raises `stb_out`. The next active edge drops `stb_out` again.
- R8: Output handshake mode with any direction bit clear runs the three-state variant. Pins whose direction bit is clear are undriven except while `stb_in` is at its active level, when all eight pins drive the latched data. `stb_out` stays high through the acknowledge and falls after its trailing edge.
- R9: With pulse style selected, each assertion event produces a pulse on `stb_out` of exactly 2 cycles in place of a level. The assertion events are entering S_IN_READY and entering S_OUT_READY.
- R10: In simple mode, a write to the auxiliary register at address 4 updates `aux_out` and pulses `stb_out` for 2 cycles, whatever the style bit says.
- R11: Outside output handshake mode, `pin_oe` equals the direction register (address 3) and `pin_out` equals the static register (address 2). A read of address 2 returns `pin_in` on bits whose direction bit is clear and the static register on the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_rd | input | 1 | Read strobe (side effects at clock edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Port pin levels |
| pin_out | output | 8 | Port pin drive data |
| pin_oe | output | 8 | Per-pin drive enable |
| stb_in | input | 1 | Edge-detected strobe / acknowledge input |
| stb_out | output | 1 | Handshake strobe output, active high |
| aux_out | output | 8 | Auxiliary output register |

## Verification
A wrong handshake state shows at `stb_out` one cycle after the edge or bus access that should have moved it. Examples are missing a capture, failing to return to ready after a read, and dropping the strobe too early in the three-state variant. A wrong edge polarity or a wrong latch enable shows up as a wrong latched value, or as an unexpected flag on the very next control read. A broken clear sequence leaves the flag stuck, or clears it early, and this is visible on the following control read. Drive errors in the three-state variant appear on `pin_oe` in the same cycle that `stb_in` changes.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_LATCH  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIRECT = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIR    = 3'd3;
    localparam logic [ADDR_W-1:0] A_AUX    = 3'd4;

    localparam int unsigned B_RISE  = 1;
    localparam int unsigned B_PULSE = 2;
    localparam int unsigned B_OUT   = 3;
    localparam int unsigned B_HS    = 4;
    localparam int unsigned B_FLAG  = 7;

    typedef enum logic [1:0] {
        M_SIMPLE = 2'd0,
        M_IN_HS  = 2'd1,
        M_OUT_HS = 2'd2
    } port_mode_e;

    typedef enum logic [2:0] {
        S_SIMPLE    = 3'd0,
        S_IN_READY  = 3'd1,
        S_IN_FULL   = 3'd2,
        S_OUT_EMPTY = 3'd3,
        S_OUT_READY = 3'd4,
        S_OUT_ACK   = 3'd5
    } hs_state_e;

    function automatic port_mode_e decode_mode(input logic hs, input logic outsel);
        if (!hs) begin
            return M_SIMPLE;
        end else if (outsel) begin
            return M_OUT_HS;
        end
        return M_IN_HS;
    endfunction

endpackage

// File: rtl/pio_hs_edge.sv
module pio_hs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_in,
    input  logic rise_sel,
    output logic act_level,
    output logic act_edge,
    output logic trail_edge
);

    logic stb_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev <= 1'b0;
        end else begin
            stb_prev <= stb_in;
        end
    end

    logic rose_w;
    logic fell_w;

    always_comb begin
        rose_w     = stb_in & ~stb_prev;
        fell_w     = ~stb_in & stb_prev;
        act_level  = rise_sel ? stb_in : ~stb_in;
        act_edge   = rise_sel ? rose_w : fell_w;
        trail_edge = rise_sel ? fell_w : rose_w;
    end

    // R3: an active edge and a trailing edge never coincide
    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_edge && trail_edge));

    // R3: an active edge leaves the strobe at its active level
    a_r3_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |-> act_level);

endmodule

// File: rtl/pio_hs_regs.sv
module pio_hs_regs
    import pio_hs_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     pin_in,
    input  logic              cap_en,
    input  logic              flag_set,
    output logic              ctrl_hs,
    output logic              ctrl_out,
    output logic              ctrl_pulse,
    output logic              ctrl_rise,
    output logic              flag,
    output logic [DW-1:0]     latch_q,
    output logic [DW-1:0]     static_q,
    output logic [DW-1:0]     dir_q,
    output logic [DW-1:0]     aux_q,
    output logic              ctrl_wr,
    output logic              latch_rd,
    output logic              latch_wr,
    output logic              aux_wr
);

    logic ctrl_rd;
    logic direct_wr;
    logic dir_wr;
    logic arm;

    always_comb begin
        ctrl_rd   = bus_rd && (bus_addr == A_CTRL);
        latch_rd  = bus_rd && (bus_addr == A_LATCH);
        ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
        latch_wr  = bus_wr && (bus_addr == A_LATCH);
        direct_wr = bus_wr && (bus_addr == A_DIRECT);
        dir_wr    = bus_wr && (bus_addr == A_DIR);
        aux_wr    = bus_wr && (bus_addr == A_AUX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_hs    <= 1'b0;
            ctrl_out   <= 1'b0;
            ctrl_pulse <= 1'b0;
            ctrl_rise  <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_hs    <= bus_wdata[B_HS];
            ctrl_out   <= bus_wdata[B_OUT];
            ctrl_pulse <= bus_wdata[B_PULSE];
            ctrl_rise  <= bus_wdata[B_RISE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            arm  <= 1'b0;
        end else begin
            if (flag_set) begin
                flag <= 1'b1;
            end else if (latch_rd && arm) begin
                flag <= 1'b0;
            end
            if (ctrl_rd) begin
                arm <= flag;
            end else if (latch_rd) begin
                arm <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '0;
            static_q <= '0;
            dir_q    <= '0;
            aux_q    <= '0;
        end else begin
            if (cap_en) begin
                latch_q <= pin_in;
            end else if (latch_wr) begin
                latch_q <= bus_wdata;
            end
            if (direct_wr) begin
                static_q <= bus_wdata;
            end
            if (dir_wr) begin
                dir_q <= bus_wdata;
            end
            if (aux_wr) begin
                aux_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_FLAG]  = flag;
                bus_rdata[B_HS]    = ctrl_hs;
                bus_rdata[B_OUT]   = ctrl_out;
                bus_rdata[B_PULSE] = ctrl_pulse;
                bus_rdata[B_RISE]  = ctrl_rise;
            end
            A_LATCH:  bus_rdata = latch_q;
            A_DIRECT: bus_rdata = (pin_in & ~dir_q) | (static_q & dir_q);
            A_DIR:    bus_rdata = dir_q;
            A_AUX:    bus_rdata = aux_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R5: the flag falls only on a latched-register read that follows an armed control read
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(latch_rd && arm));

    // R5: the flag rises only after an active strobe edge
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(flag_set));

    // R2: the unused control bits always read as zero
    a_r2_ctrl_spare: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[6:5] == 2'b00 && bus_rdata[0] == 1'b0));

endmodule

// File: rtl/pio_hs_fsm.sv
module pio_hs_fsm
    import pio_hs_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  port_mode_e new_mode,
    input  logic       pulse_sel,
    input  logic       tri_var,
    input  logic       act_edge,
    input  logic       trail_edge,
    input  logic       latch_rd,
    input  logic       latch_wr,
    input  logic       aux_wr,
    output hs_state_e  state_q,
    output logic       stb_out
);

    localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

    hs_state_e        state_d;
    logic             assert_ev;
    logic [CNT_W-1:0] pulse_cnt;
    logic             level_on;
    logic             pulse_only;

    always_comb begin
        state_d   = state_q;
        assert_ev = 1'b0;
        if (ctrl_wr) begin
            unique case (new_mode)
                M_SIMPLE: state_d = S_SIMPLE;
                M_IN_HS: begin
                    state_d   = S_IN_READY;
                    assert_ev = 1'b1;
                end
                M_OUT_HS: state_d = S_OUT_EMPTY;
                default:  state_d = S_SIMPLE;
            endcase
        end else begin
            unique case (state_q)
                S_SIMPLE: begin
                    if (aux_wr) begin
                        assert_ev = 1'b1;
                    end
                end
                S_IN_READY: begin
                    if (act_edge) begin
                        state_d = S_IN_FULL;
                    end
                end
                S_IN_FULL: begin
                    if (latch_rd) begin
                        state_d   = S_IN_READY;
                        assert_ev = 1'b1;
                    end
                end
                S_OUT_EMPTY: begin
                    if (latch_wr) begin
                        state_d   = S_OUT_READY;
                        assert_ev = 1'b1;
                    end
                end
                S_OUT_READY: begin
                    if (act_edge) begin
                        state_d = tri_var ? S_OUT_ACK : S_OUT_EMPTY;
                    end
                end
                S_OUT_ACK: begin
                    if (trail_edge) begin
                        state_d = S_OUT_EMPTY;
                    end
                end
                default: state_d = S_SIMPLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_SIMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
        end else if (assert_ev) begin
            pulse_cnt <= CNT_W'(PULSE_LEN);
        end else if (pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    always_comb begin
        level_on   = (state_q == S_IN_READY) || (state_q == S_OUT_READY) ||
                     (state_q == S_OUT_ACK);
        pulse_only = pulse_sel || (state_q == S_SIMPLE);
        stb_out    = pulse_only ? (pulse_cnt != '0) : level_on;
    end

    // R9: a pulse-style strobe stays high for at least its second cycle
    a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_only && $rose(stb_out)) |=> (stb_out || !pulse_only));

    // R6: S_IN_FULL is entered only through an active strobe edge
    a_r6_full_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state_q == S_IN_FULL)) |-> $past(act_edge));

    // R8: S_OUT_ACK is left only through a trailing edge or a control write
    a_r8_ack_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == S_OUT_ACK) && state_q != S_OUT_ACK) |-> $past(trail_edge || ctrl_wr));

endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port
    import pio_hs_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned PULSE_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     pin_in,
    output logic [DW-1:0]     pin_out,
    output logic [DW-1:0]     pin_oe,
    input  logic              stb_in,
    output logic              stb_out,
    output logic [DW-1:0]     aux_out
);

    logic       act_level;
    logic       act_edge;
    logic       trail_edge;
    logic       ctrl_hs;
    logic       ctrl_out;
    logic       ctrl_pulse;
    logic       ctrl_rise;
    logic       flag;
    logic       ctrl_wr;
    logic       latch_rd;
    logic       latch_wr;
    logic       aux_wr;
    logic       cap_en;
    logic       tri_var;
    logic [DW-1:0] latch_q;
    logic [DW-1:0] static_q;
    logic [DW-1:0] dir_q;
    port_mode_e mode;
    port_mode_e new_mode;
    hs_state_e  state_q;

    pio_hs_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_in     (stb_in),
        .rise_sel   (ctrl_rise),
        .act_level  (act_level),
        .act_edge   (act_edge),
        .trail_edge (trail_edge)
    );

    always_comb begin
        mode     = decode_mode(ctrl_hs, ctrl_out);
        new_mode = decode_mode(bus_wdata[B_HS], bus_wdata[B_OUT]);
        cap_en   = act_edge && (mode != M_OUT_HS);
        tri_var  = (dir_q != {DW{1'b1}});
    end

    pio_hs_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .cap_en     (cap_en),
        .flag_set   (act_edge),
        .ctrl_hs    (ctrl_hs),
        .ctrl_out   (ctrl_out),
        .ctrl_pulse (ctrl_pulse),
        .ctrl_rise  (ctrl_rise),
        .flag       (flag),
        .latch_q    (latch_q),
        .static_q   (static_q),
        .dir_q      (dir_q),
        .aux_q      (aux_out),
        .ctrl_wr    (ctrl_wr),
        .latch_rd   (latch_rd),
        .latch_wr   (latch_wr),
        .aux_wr     (aux_wr)
    );

    pio_hs_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .new_mode   (new_mode),
        .pulse_sel  (ctrl_pulse),
        .tri_var    (tri_var),
        .act_edge   (act_edge),
        .trail_edge (trail_edge),
        .latch_rd   (latch_rd),
        .latch_wr   (latch_wr),
        .aux_wr     (aux_wr),
        .state_q    (state_q),
        .stb_out    (stb_out)
    );

    always_comb begin
        if (mode == M_OUT_HS) begin
            pin_out = latch_q;
            pin_oe  = act_level ? {DW{1'b1}} : dir_q;
        end else begin
            pin_out = static_q;
            pin_oe  = dir_q;
        end
    end

    // R8: an active acknowledge in output handshake drives every pin
    a_r8_all_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OUT_HS && act_level) |-> (pin_oe == {DW{1'b1}}));

    // R11: outside output handshake the drive enables follow the direction register
    a_r11_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != M_OUT_HS) |-> (pin_oe == dir_q));

    // R4: a capturing edge moves the latched data to the sampled pins
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_en) |-> (latch_q == $past(pin_in)));

    // R7: the output handshake state is reachable only in output mode
    a_r7_mode_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OUT_READY) |-> (mode == M_OUT_HS));

endmodule

// File: tb/test_pio_hs_port.sv
`timescale 1ns/1ps
module test_pio_hs_port;

    localparam int unsigned MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       stb_in = 1'b0;
    logic       stb_out;
    logic [7:0] aux_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_hs_port i_pio_hs_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .stb_in    (stb_in),
        .stb_out   (stb_out),
        .aux_out   (aux_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(8.0 * MAX_CYCLES);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd_chk("R1 ctrl", 3'd0, 8'h00);
        rd_chk("R1 dir", 3'd3, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 stb_out", {7'd0, stb_out}, 8'h00);

        // R2: control layout sweep over every write value
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 8'(v));
            rd_chk("R2 ctrl readback", 3'd0, 8'(v) & 8'h1E);
        end
        wr(3'd0, 8'h00);
        repeat (3) tick();

        // R11: direction and static data in simple and input handshake modes
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            logic [7:0] s;
            logic [7:0] p;
            d = 8'(i * 29) ^ 8'h5A;
            s = 8'(i * 59 + 7);
            p = ~8'(i * 97);
            wr(3'd0, (i % 2 == 1) ? 8'h12 : 8'h00);
            wr(3'd3, d);
            wr(3'd2, s);
            pin_in = p;
            rd_chk("R11 direct read", 3'd2, (p & ~d) | (s & d));
            chk("R11 pin_oe", pin_oe, d);
            chk("R11 pin_out", pin_out, s);
        end
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h00);
        tick();

        // R3 R4 R5: rising edge capture in simple mode
        wr(3'd0, 8'h02);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'(i * 37 + 11);
            pin_in = v;
            stb_in = 1'b1;
            tick();
            pin_in = ~v;
            stb_in = 1'b0;
            tick();
            rd_chk("R4 rising capture", 3'd1, v);
            rd_chk("R5 flag kept after bare read", 3'd0, 8'h82);
            rd_chk("R3 falling edge ignored", 3'd1, v);
            rd_chk("R5 flag cleared", 3'd0, 8'h02);
        end

        // R3 R4 R5: falling edge capture in simple mode
        wr(3'd0, 8'h00);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'(i * 53 + 3);
            pin_in = v;
            stb_in = 1'b1;
            tick();
            rd_chk("R3 rising edge ignored", 3'd0, 8'h00);
            stb_in = 1'b0;
            tick();
            pin_in = ~v;
            rd_chk("R4 falling capture", 3'd1, v);
            rd_chk("R5 flag set", 3'd0, 8'h80);
            rd_chk("R4 latch held", 3'd1, v);
            rd_chk("R5 flag cleared", 3'd0, 8'h00);
        end

        // R6: input handshake, level style
        wr(3'd0, 8'h12);
        chk("R6 ready high", {7'd0, stb_out}, 8'h01);
        pin_in = 8'hA5;
        stb_in = 1'b1;
        tick();
        chk("R6 low after capture", {7'd0, stb_out}, 8'h00);
        rd_chk("R6 flag", 3'd0, 8'h92);
        rd_chk("R6 latched", 3'd1, 8'hA5);
        chk("R6 ready again", {7'd0, stb_out}, 8'h01);
        rd_chk("R6 flag cleared", 3'd0, 8'h12);
        stb_in = 1'b0;
        tick();

        // R9: input handshake, pulse style
        wr(3'd0, 8'h16);
        chk("R9 pulse c1", {7'd0, stb_out}, 8'h01);
        tick();
        chk("R9 pulse c2", {7'd0, stb_out}, 8'h01);
        tick();
        chk("R9 pulse end", {7'd0, stb_out}, 8'h00);
        pin_in = 8'h3C;
        stb_in = 1'b1;
        tick();
        chk("R9 no pulse on capture", {7'd0, stb_out}, 8'h00);
        rd_chk("R9 flag", 3'd0, 8'h96);
        rd_chk("R9 latched", 3'd1, 8'h3C);
        chk("R9 re-ready c1", {7'd0, stb_out}, 8'h01);
        tick();
        chk("R9 re-ready c2", {7'd0, stb_out}, 8'h01);
        tick();
        chk("R9 re-ready end", {7'd0, stb_out}, 8'h00);
        stb_in = 1'b0;
        tick();

        // R10: simple mode auxiliary write pulses, style bit clear and set
        for (int k = 0; k < 2; k++) begin
            logic [7:0] v;
            v = (k == 0) ? 8'h3C : 8'hC3;
            wr(3'd0, (k == 0) ? 8'h00 : 8'h04);
            tick();
            tick();
            wr(3'd4, v);
            chk("R10 aux_out", aux_out, v);
            chk("R10 pulse c1", {7'd0, stb_out}, 8'h01);
            tick();
            chk("R10 pulse c2", {7'd0, stb_out}, 8'h01);
            tick();
            chk("R10 pulse end", {7'd0, stb_out}, 8'h00);
        end

        // R7: output handshake with all pins outputs
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h1A);
        chk("R7 idle low", {7'd0, stb_out}, 8'h00);
        wr(3'd1, 8'h96);
        chk("R7 data ready", {7'd0, stb_out}, 8'h01);
        chk("R7 pin_out", pin_out, 8'h96);
        chk("R7 pin_oe", pin_oe, 8'hFF);
        stb_in = 1'b1;
        tick();
        chk("R7 ack drops strobe", {7'd0, stb_out}, 8'h00);
        rd_chk("R7 flag", 3'd0, 8'h9A);
        rd_chk("R7 clear read", 3'd1, 8'h96);
        stb_in = 1'b0;
        tick();
        rd_chk("R7 flag cleared", 3'd0, 8'h1A);

        // R8: three-state variant over several direction patterns
        for (int j = 0; j < 4; j++) begin
            logic [7:0] d;
            logic [7:0] v;
            d = (j == 0) ? 8'h0F : (j == 1) ? 8'h00 : (j == 2) ? 8'hF0 : 8'h7E;
            v = 8'hC3 ^ d;
            wr(3'd3, d);
            wr(3'd0, 8'h1A);
            wr(3'd1, v);
            chk("R8 data ready", {7'd0, stb_out}, 8'h01);
            chk("R8 floating pins", pin_oe, d);
            chk("R8 pin_out", pin_out, v);
            stb_in = 1'b1;
            #1;
            chk("R8 all drive", pin_oe, 8'hFF);
            tick();
            chk("R8 held during ack", {7'd0, stb_out}, 8'h01);
            tick();
            chk("R8 still held", {7'd0, stb_out}, 8'h01);
            stb_in = 1'b0;
            #1;
            chk("R8 float again", pin_oe, d);
            tick();
            chk("R8 drop after trailing", {7'd0, stb_out}, 8'h00);
            rd_chk("R8 flag", 3'd0, 8'h9A);
            rd_chk("R8 clear read", 3'd1, v);
            rd_chk("R8 flag cleared", 3'd0, 8'h1A);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule